// File: doc/BRIEF.md
# I2C Master Event and Interrupt Status Unit

This unit gathers the event flags raised by the bit engine of an I2C master controller. Each event arrives as a one-cycle pulse and sets a sticky flag in a 16-bit status word. A matching enable word selects which flags may drive the single interrupt line. Software clears a flag by writing a one to its position. A compact vector register also reports the most urgent of the five basic events as a small code. Reading that register clears the event it reported, so an older handler can work through the events one read at a time.

The bus-busy flag does not latch. It is a live copy of the bus state and never responds to writes. Registers are reached through a plain single-cycle port. Read data is combinational from the address, and register updates take effect at the next clock edge. Address map: 0 = status, 1 = enable, 2 = vector, 3 = reads zero.

Top module: `i2c_evt_status`

## Requirements
- R1: A pulse on `evtPulse[b]` sets status bit b at the next edge for the latching positions 0 (arbitration lost), 1 (no-acknowledge), 2 (access ready), 3 (receive ready), 4 (transmit ready), 8 (address zero), 9 (addressed as slave), 10 (transmit underflow), 11 (receive overrun), 13 (receive drain) and 14 (transmit drain).
- R2: A set status flag stays set until it is cleared.
- R3: A write to address 0 clears every latching status bit whose data bit is 1 and leaves the bits with data 0 unchanged.
- R4: When an event pulse and a clear (by write or by vector read) hit the same bit in the same cycle, the bit ends up set.
- R5: Status bit 12 always equals the `busBusy` input. Writes and pulses on position 12 have no effect on it.
- R6: Enable bits 0–4, 13 and 14 are written through address 1 and read back. All other enable bits read 0.
- R7: `irqOut` is 1 exactly when some status bit and the enable bit at the same position are both 1.
- R8: Address 2 reads a code in bits 2:0 that is chosen from status bits 0–4 without regard to the enables: 0 none, 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready. When several of these are set, the lowest nonzero code is reported.
- R9: A read of address 2 clears only the status bit that belongs to the code returned. A read that returns 0 clears nothing.
- R10: After reset, status reads only the live bus-busy bit, the enable register reads 0, the vector reads 0 and `irqOut` is 0.
- R11: Status bits 5–7 and 15 always read 0, even when pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 16 | One-cycle event pulses from the bus engine, one per status position |
| busBusy | input | 1 | Live bus-busy level |
| regAddr | input | 2 | Register address |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe; clears the reported event when the address is 2 |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for the current address |
| irqOut | output | 1 | Interrupt request |

## Verification
The assertions assume that a read and a write never occur in the same cycle. They also assume that `evtPulse` and `busBusy` change only between edges. The set-wins and clear checks hold without assuming anything about how events are spaced. The bench drives every input on the falling edge and never raises both strobes at once. It sweeps every status position, every enable position and all 32 combinations of the five coded events. It also places event pulses on the same cycle as clearing writes and vector reads.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 2;
  localparam int VEC_W   = 3;
  localparam int NUM_VEC = 5;   // coded events occupy status bits 0..NUM_VEC-1

  localparam int BUSY_POS = 12;
  localparam logic [REG_W-1:0] LATCH_MASK  = 16'h6F1F;
  localparam logic [REG_W-1:0] ENABLE_MASK = 16'h601F;

  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_IEN  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_VEC  = 2'd2;

  typedef struct packed {
    logic             statClr;  // write-one-to-clear on status
    logic             enLoad;   // load enable register
    logic [REG_W-1:0] vecClr;   // one-hot clear from a vector read
  } accStrobe_t;
endpackage

// File: rtl/i2c_evt_ctrl.sv
module i2c_evt_ctrl
  import i2c_evt_pkg::*;
(
  input  logic               regWr,
  input  logic               regRd,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_VEC-1:0] codedFlags,
  output logic [VEC_W-1:0]   vecCode,
  output accStrobe_t         strb
);
  logic [REG_W-1:0] pickOneHot;

  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    vecCode    = '0;
    pickOneHot = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (codedFlags[i]) begin
        vecCode    = VEC_W'(i + 1);
        pickOneHot = REG_W'(1) << i;
      end
    end
  end

  always_comb begin
    strb.statClr = regWr && (regAddr == ADDR_STAT);
    strb.enLoad  = regWr && (regAddr == ADDR_IEN);
    strb.vecClr  = (regRd && (regAddr == ADDR_VEC)) ? pickOneHot : '0;
  end
endmodule

// File: rtl/i2c_evt_dpath.sv
module i2c_evt_dpath
  import i2c_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  evtPulse,
  input  logic              busBusy,
  input  logic [REG_W-1:0]  wData,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [VEC_W-1:0]  vecCode,
  input  accStrobe_t        strb,
  output logic [REG_W-1:0]  statusQ,
  output logic [REG_W-1:0]  enableQ,
  output logic [REG_W-1:0]  rdData,
  output logic              irqOut
);
  logic [REG_W-1:0] wrClr;
  logic [REG_W-1:0] clrAll;

  assign wrClr  = strb.statClr ? wData : '0;
  assign clrAll = wrClr | strb.vecClr;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (LATCH_MASK[b]) begin : g_latch
      logic flagQ;
      always_ff @(posedge clk) begin
        if (!rstN)            flagQ <= 1'b0;
        else if (evtPulse[b]) flagQ <= 1'b1;
        else if (clrAll[b])   flagQ <= 1'b0;
      end
      assign statusQ[b] = flagQ;
    end else if (b == BUSY_POS) begin : g_busy
      assign statusQ[b] = busBusy;
    end else begin : g_rsvd
      assign statusQ[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            enableQ <= '0;
    else if (strb.enLoad) enableQ <= wData & ENABLE_MASK;
  end

  assign irqOut = |(statusQ & enableQ);

  always_comb begin
    case (regAddr)
      ADDR_STAT: rdData = statusQ;
      ADDR_IEN:  rdData = enableQ;
      ADDR_VEC:  rdData = {{(REG_W-VEC_W){1'b0}}, vecCode};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
  import i2c_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  evtPulse,
  input  logic              busBusy,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              irqOut
);
  accStrobe_t       strb;
  logic [VEC_W-1:0] vecCode;
  logic [REG_W-1:0] statusQ;
  logic [REG_W-1:0] enableQ;

  i2c_evt_ctrl u_ctrl (
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .codedFlags(statusQ[NUM_VEC-1:0]), .vecCode(vecCode), .strb(strb)
  );

  i2c_evt_dpath u_dpath (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .busBusy(busBusy),
    .wData(regWdata), .regAddr(regAddr), .vecCode(vecCode), .strb(strb),
    .statusQ(statusQ), .enableQ(enableQ), .rdData(regRdata), .irqOut(irqOut)
  );
endmodule

// File: rtl/i2c_evt_chk.sv
module i2c_evt_chk
  import i2c_evt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [REG_W-1:0]  evtPulse,
  input logic              busBusy,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWr,
  input logic              regRd,
  input logic [REG_W-1:0]  regWdata,
  input logic [REG_W-1:0]  statusQ,
  input logic [REG_W-1:0]  enableQ,
  input logic [VEC_W-1:0]  vecCode,
  input logic              irqOut
);
  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
    (|(evtPulse & LATCH_MASK)) |=>
      ((statusQ & $past(evtPulse & LATCH_MASK)) == $past(evtPulse & LATCH_MASK))); // R1 R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_STAT) |=>
      ((statusQ & $past(regWdata & LATCH_MASK & ~evtPulse)) == '0)); // R3

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!regWr && !regRd) |=> ((statusQ & LATCH_MASK) == ($past(statusQ) & LATCH_MASK))
      || ((statusQ & LATCH_MASK) != ($past(statusQ) & LATCH_MASK) && |$past(evtPulse))); // R2

  AST_ENABLE_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ & ~ENABLE_MASK) == '0); // R6

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|enableQ)); // R7

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    vecCode <= VEC_W'(NUM_VEC)); // R8

  AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~(LATCH_MASK | (REG_W'(1) << BUSY_POS))) == '0); // R11

  AST_BUSY_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[BUSY_POS] == busBusy); // R5
endmodule

bind i2c_evt_status i2c_evt_chk u_chk (
  .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .busBusy(busBusy),
  .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
  .statusQ(statusQ), .enableQ(enableQ), .vecCode(vecCode), .irqOut(irqOut)
);

// File: tb/i2c_evt_status_tb.sv
module i2c_evt_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] LATCH = 16'h6F1F;
  localparam logic [15:0] ENMSK = 16'h601F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] evtPulse = '0;
  logic        busBusy = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_evt_status u_dut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .busBusy(busBusy),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle with optional pulse and optional write; returns at next negedge
  task automatic cycle(input logic [15:0] pls, input logic wr, input logic [1:0] a,
                       input logic [15:0] d);
    evtPulse = pls; regWr = wr; regAddr = a; regWdata = d;
    @(negedge clk);
    evtPulse = '0; regWr = 1'b0; regWdata = '0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    regAddr = a; #1 v = regRdata;
  endtask

  // vector read with optional simultaneous pulse
  task automatic vecRead(input logic [15:0] pls, output logic [15:0] v);
    regAddr = 2'd2; regRd = 1'b1; evtPulse = pls;
    #1 v = regRdata;
    @(negedge clk);
    regRd = 1'b0; evtPulse = '0;
  endtask

  function automatic logic [15:0] lowCode(input logic [15:0] st);
    for (int i = 0; i < 5; i++) if (st[i]) return 16'(i + 1);
    return 16'd0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] exp;
    busBusy = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    peek(2'd0, v); check("R10 status after reset", v, 16'h1000);
    peek(2'd1, v); check("R10 enable after reset", v, 16'h0000);
    peek(2'd2, v); check("R10 vector after reset", v, 16'h0000);
    check("R10 irq after reset", 16'(irqOut), 16'h0);
    busBusy = 1'b0;

    // R1 R11 R2 R3: each position pulsed, held, then cleared
    for (int b = 0; b < 16; b++) begin
      cycle(16'(1) << b, 1'b0, 2'd0, '0);
      exp = (16'(1) << b) & LATCH;
      peek(2'd0, v); check("R1 R11 pulse sets", v, exp);
      cycle('0, 1'b0, 2'd0, '0); cycle('0, 1'b0, 2'd0, '0);
      peek(2'd0, v); check("R2 flag held", v, exp);
      cycle('0, 1'b1, 2'd0, ~(16'(1) << b));
      peek(2'd0, v); check("R3 zero write keeps", v, exp);
      cycle('0, 1'b1, 2'd0, 16'(1) << b);
      peek(2'd0, v); check("R3 one write clears", v, 16'h0);
    end

    // R3 partial clear
    cycle(16'hFFFF, 1'b0, 2'd0, '0);
    cycle('0, 1'b1, 2'd0, 16'h0F0F);
    peek(2'd0, v); check("R3 partial clear", v, LATCH & ~16'h0F0F);
    cycle('0, 1'b1, 2'd0, 16'hFFFF);

    // R4 set wins over write clear
    cycle(16'h0003, 1'b1, 2'd0, 16'h0003);
    peek(2'd0, v); check("R4 set beats write clear", v, 16'h0003);
    cycle('0, 1'b1, 2'd0, 16'hFFFF);

    // R5 busy follows input, ignores write and pulse
    busBusy = 1'b1; #1 peek(2'd0, v); check("R5 busy high", v, 16'h1000);
    cycle(16'h1000, 1'b1, 2'd0, 16'h1000);
    peek(2'd0, v); check("R5 busy ignores write", v, 16'h1000);
    busBusy = 1'b0; #1 peek(2'd0, v); check("R5 busy low", v, 16'h0000);
    cycle(16'h1000, 1'b0, 2'd0, '0);
    peek(2'd0, v); check("R5 busy ignores pulse", v, 16'h0000);

    // R6 enable sweep
    for (int b = 0; b < 16; b++) begin
      cycle('0, 1'b1, 2'd1, 16'(1) << b);
      peek(2'd1, v); check("R6 enable bit", v, (16'(1) << b) & ENMSK);
    end

    // R7 irq sweep: event alone, matching enable, other enable
    for (int b = 0; b < 16; b++) begin
      if (ENMSK[b]) begin
        cycle('0, 1'b1, 2'd1, '0);
        cycle(16'(1) << b, 1'b0, 2'd0, '0);
        check("R7 irq masked", 16'(irqOut), 16'h0);
        cycle('0, 1'b1, 2'd1, ENMSK & ~(16'(1) << b));
        check("R7 irq other enable", 16'(irqOut), 16'h0);
        cycle('0, 1'b1, 2'd1, 16'(1) << b);
        check("R7 irq asserted", 16'(irqOut), 16'h1);
        cycle('0, 1'b1, 2'd0, 16'(1) << b);
        check("R7 irq drops on clear", 16'(irqOut), 16'h0);
      end
    end
    cycle('0, 1'b1, 2'd1, '0);

    // R8 R9 all 32 combinations of coded events, enables off
    for (int m = 0; m < 32; m++) begin
      logic [15:0] model;
      model = 16'(m);
      cycle(model | 16'h0100, 1'b0, 2'd0, '0);
      for (int k = 0; k < 6; k++) begin
        exp = lowCode(model);
        vecRead('0, v); check("R8 vector code", v, exp);
        if (exp != 0) model[exp - 1] = 1'b0;
        peek(2'd0, v); check("R9 read clears one", v, model | 16'h0100);
      end
      cycle('0, 1'b1, 2'd0, 16'hFFFF);
    end

    // R4 set beats vector-read clear
    cycle(16'h0004, 1'b0, 2'd0, '0);
    vecRead(16'h0004, v); check("R8 code access ready", v, 16'd3);
    peek(2'd0, v); check("R4 set beats read clear", v, 16'h0004);
    peek(2'd3, v); check("R10 unused address zero", v, 16'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule